// File: doc/BRIEF.md
# Zero-Suppressing Seven-Segment Display Decoder

This block turns a row of BCD digits into seven-segment patterns, one pattern per digit. It suppresses non-significant zeros on both sides of a decimal point whose position is set at run time. On the integer side, suppression starts at the most significant digit and moves toward the point. On the fractional side, it starts at the least significant digit and moves toward the point. Suppression stops at the first digit that is non-zero. It also stops at a digit whose per-digit allow strap is low, so that digit shows its zero.

Two global controls act on the segments. Lamp test lights every segment. Display enable blanks the whole row without stopping the zero-suppression logic, and it is passed on to an output so that other digit groups can share the same on-period.

All outputs are registered, so they follow the inputs one clock later. The reset is asserted asynchronously and released in step with the clock.

Top module: `zsup_seg_decoder`

## Requirements
- R1: Segment bit k of a digit's 7-bit field drives segment a+k, so bit 0 is a and bit 6 is g. For BCD values 0..9 the fields are 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F. Digit i occupies `digits_i[4i+3:4i]` and `seg_o[7i+6:7i]`, and digit 0 is the least significant.
- R2: BCD values 10 to 15 give an all-zero segment field. These values count as non-zero, so they stop suppression.
- R3: `point_i` = p gives the number of fractional digits. Digits p..NDIG-1 are integer digits, and digits 0..p-1 are fractional digits. Integer digit i is blanked when every digit from NDIG-1 down to i holds value 0 and has its allow strap set.
- R4: Fractional digit i is blanked when every digit from 0 up to i holds value 0 and has its allow strap set.
- R5: An allow strap of 0 on a digit makes that digit show its zero. It also stops suppression for every digit further along the same chain.
- R6: `blank_o[i]` is 1 exactly when digit i is suppressed by R3 or R4. A suppressed digit has an all-zero segment field when the display is enabled and lamp test is off.
- R7: With `disp_en_i` = 1 and `lamp_test_i` = 1, every segment bit is 1, whatever the digit values are.
- R8: With `disp_en_i` = 0, every segment bit is 0, and this holds even when lamp test is high. `blank_o` keeps following R3 and R4.
- R9: `disp_en_o` copies `disp_en_i` with a latency of one clock.
- R10: A `point_i` value above NDIG is treated as NDIG, which means all digits are fractional.
- R11: While reset is active, `seg_o`, `blank_o` and `disp_en_o` are all 0. After reset, every output reflects the inputs sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digits_i | input | 4*NDIG | BCD digits, digit 0 in the low nibble |
| point_i | input | $clog2(NDIG+1) | Number of fractional digits |
| allow_i | input | NDIG | Per-digit zero-suppression allow strap |
| lamp_test_i | input | 1 | Forces all segments on |
| disp_en_i | input | 1 | Display enable; low blanks all segments |
| seg_o | output | 7*NDIG | Segment fields, bit 0 = a |
| blank_o | output | NDIG | Per-digit suppressed flag |
| disp_en_o | output | 1 | Registered copy of disp_en_i |

## Verification
The hardest case to reach is a chain that is cut in the middle. This happens when a run of suppressed zeros ends at a digit that is either non-zero or has its strap low. The run must end at exactly that digit, and it must not spill over the point into the other chain. The stimulus builds every 4-digit pattern from the values 0, 1 and 10. It combines each pattern with all 16 strap settings and every point code, including the out-of-range codes. Every possible break position therefore occurs in both directions.

// File: rtl/zsup_pkg.sv
package zsup_pkg;
  localparam int unsigned SEG_W = 7;
  localparam int unsigned BCD_W = 4;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [BCD_W-1:0] bcd_t;

  // bit 0 = segment a ... bit 6 = segment g
  function automatic seg_t seg_of(bcd_t v);
    seg_t s;
    case (v)
      4'd0:    s = 7'h3F;
      4'd1:    s = 7'h06;
      4'd2:    s = 7'h5B;
      4'd3:    s = 7'h4F;
      4'd4:    s = 7'h66;
      4'd5:    s = 7'h6D;
      4'd6:    s = 7'h7D;
      4'd7:    s = 7'h07;
      4'd8:    s = 7'h7F;
      4'd9:    s = 7'h6F;
      default: s = 7'h00; // R2: non-decimal codes dark
    endcase
    return s;
  endfunction
endpackage

// File: rtl/zsup_rst_sync.sv
module zsup_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/zsup_chain.sv
module zsup_chain #(
  parameter int unsigned NDIG = 4,
  parameter int unsigned PW   = $clog2(NDIG + 1)
) (
  input  logic [NDIG*4-1:0] digits,
  input  logic [PW-1:0]     point,
  input  logic [NDIG-1:0]   allow,
  output logic [NDIG-1:0]   blank
);
  logic [NDIG-1:0] is_zero;
  int              pnt;
  logic            run_int;
  logic            run_frac;

  always_comb begin
    for (int i = 0; i < NDIG; i++) is_zero[i] = (digits[i*4 +: 4] == 4'd0);
  end

  // R10: out-of-range point clamps to NDIG
  always_comb begin
    if (int'(point) > int'(NDIG)) pnt = int'(NDIG);
    else                           pnt = int'(point);
  end

  // R3 integer chain from the top, R4 fractional chain from the bottom
  always_comb begin
    blank    = '0;
    run_int  = 1'b1;
    for (int i = NDIG - 1; i >= 0; i--) begin
      if (i >= pnt) begin
        run_int  = run_int & allow[i] & is_zero[i];
        blank[i] = run_int;
      end
    end
    run_frac = 1'b1;
    for (int i = 0; i < NDIG; i++) begin
      if (i < pnt) begin
        run_frac = run_frac & allow[i] & is_zero[i];
        blank[i] = run_frac;
      end
    end
  end
endmodule

// File: rtl/zsup_digit_enc.sv
module zsup_digit_enc
  import zsup_pkg::*;
(
  input  bcd_t bcd,
  input  logic blank,
  input  logic lamp_test,
  input  logic disp_en,
  output seg_t seg
);
  always_comb begin
    if (!disp_en)       seg = '0;      // R8
    else if (lamp_test) seg = '1;      // R7
    else if (blank)     seg = '0;      // R6
    else                seg = seg_of(bcd);
  end
endmodule

// File: rtl/zsup_seg_decoder.sv
module zsup_seg_decoder
  import zsup_pkg::*;
#(
  parameter int unsigned NDIG = 4,
  localparam int unsigned PW  = $clog2(NDIG + 1),
  localparam int unsigned SW  = NDIG * SEG_W,
  localparam int unsigned DW  = NDIG * BCD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] digits_i,
  input  logic [PW-1:0] point_i,
  input  logic [NDIG-1:0] allow_i,
  input  logic          lamp_test_i,
  input  logic          disp_en_i,
  output logic [SW-1:0] seg_o,
  output logic [NDIG-1:0] blank_o,
  output logic          disp_en_o
);
  logic            rst_ns;
  logic [NDIG-1:0] blank_w;
  logic [SW-1:0]   seg_d, seg_q;
  logic [NDIG-1:0] blank_d, blank_q;
  logic            en_d, en_q;

  zsup_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_ns)
  );

  zsup_chain #(.NDIG(NDIG), .PW(PW)) u_chain (
    .digits (digits_i),
    .point  (point_i),
    .allow  (allow_i),
    .blank  (blank_w)
  );

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    zsup_digit_enc u_enc (
      .bcd       (digits_i[g*BCD_W +: BCD_W]),
      .blank     (blank_w[g]),
      .lamp_test (lamp_test_i),
      .disp_en   (disp_en_i),
      .seg       (seg_d[g*SEG_W +: SEG_W])
    );

    // R6: a suppressed digit reaches the pins dark
    p_blank_dark_r6: assert property (@(posedge clk) disable iff (!rst_ns)
      (disp_en_i && !lamp_test_i && blank_w[g]) |=> (seg_q[g*SEG_W +: SEG_W] == '0));
  end

  // next state
  always_comb begin
    blank_d = blank_w;
    en_d    = disp_en_i;
  end

  // registers (R11)
  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      seg_q   <= '0;
      blank_q <= '0;
      en_q    <= 1'b0;
    end else begin
      seg_q   <= seg_d;
      blank_q <= blank_d;
      en_q    <= en_d;
    end
  end

  assign seg_o     = seg_q;
  assign blank_o   = blank_q;
  assign disp_en_o = en_q;

  p_lamp_on_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (disp_en_i && lamp_test_i) |=> (&seg_q));

  p_dark_off_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (!disp_en_i) |=> (seg_q == '0));

  p_en_high_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    disp_en_i |=> disp_en_o);

  p_en_low_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    !disp_en_i |=> !disp_en_o);

  p_reset_quiet_r11: assert property (@(posedge clk)
    (!rst_ns) |-> (seg_q == '0 && blank_q == '0 && !en_q));
endmodule

// File: tb/zsup_seg_decoder_test.sv
module zsup_seg_decoder_test;
  localparam int NDIG = 4;
  localparam int PW   = $clog2(NDIG + 1);

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NDIG*4-1:0] digits;
  logic [PW-1:0]     point;
  logic [NDIG-1:0]   allow;
  logic              lamp, en;
  logic [NDIG*7-1:0] seg;
  logic [NDIG-1:0]   blank;
  logic              en_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk; // 50 MHz

  zsup_seg_decoder #(.NDIG(NDIG)) uut (
    .clk(clk), .rst_n(rst_n), .digits_i(digits), .point_i(point),
    .allow_i(allow), .lamp_test_i(lamp), .disp_en_i(en),
    .seg_o(seg), .blank_o(blank), .disp_en_o(en_out)
  );

  function automatic logic [6:0] ref_seg(input logic [3:0] v);
    case (v)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic expect_out(output logic [NDIG*7-1:0] es, output logic [NDIG-1:0] eb);
    int  p;
    bit  go;
    p  = (int'(point) > NDIG) ? NDIG : int'(point); // R10
    eb = '0;
    go = 1;
    for (int i = NDIG - 1; i >= p; i--) begin   // R3
      go = go && allow[i] && (digits[i*4 +: 4] == 0);
      eb[i] = go;
    end
    go = 1;
    for (int i = 0; i < p; i++) begin           // R4
      go = go && allow[i] && (digits[i*4 +: 4] == 0);
      eb[i] = go;
    end
    for (int i = 0; i < NDIG; i++) begin
      if (!en)         es[i*7 +: 7] = 7'h00;
      else if (lamp)   es[i*7 +: 7] = 7'h7F;
      else if (eb[i])  es[i*7 +: 7] = 7'h00;
      else             es[i*7 +: 7] = ref_seg(digits[i*4 +: 4]);
    end
  endtask

  task automatic apply_check(input string tag);
    logic [NDIG*7-1:0] es;
    logic [NDIG-1:0]   eb;
    expect_out(es, eb);
    @(negedge clk);
    checks++;
    if (seg !== es || blank !== eb || en_out !== en) begin
      errors++;
      $display("FAIL %s: seg=%h blank=%b en=%b expected seg=%h blank=%b en=%b",
               tag, seg, blank, en_out, es, eb, en);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; digits = '0; point = '0; allow = '0; lamp = 1'b1; en = 1'b1;
    repeat (3) @(negedge clk);
    checks++; // R11 reset state
    if (seg !== '0 || blank !== '0 || en_out !== 1'b0) begin
      errors++;
      $display("FAIL R11: seg=%h blank=%b en=%b expected all zero", seg, blank, en_out);
    end
    rst_n = 1'b1;
    lamp  = 1'b0;
    repeat (3) @(negedge clk);

    // R1 R2: every code in every position, no suppression
    for (int v = 0; v < 16; v++) begin
      digits = {NDIG{4'(v)}};
      allow  = '0;
      point  = 3'(v % (NDIG + 1));
      apply_check("R1/R2");
    end

    // R3 R4 R5 R6 R10: patterns of 0, 1, 10 with all straps and point codes
    for (int p = 0; p < (1 << PW); p++) begin
      for (int a = 0; a < (1 << NDIG); a++) begin
        for (int c = 0; c < 81; c++) begin
          int r = c;
          for (int i = 0; i < NDIG; i++) begin
            case (r % 3)
              0: digits[i*4 +: 4] = 4'd0;
              1: digits[i*4 +: 4] = 4'd1;
              default: digits[i*4 +: 4] = 4'd10;
            endcase
            r = r / 3;
          end
          point = PW'(p);
          allow = NDIG'(a);
          apply_check("R3/R4/R5/R6/R10");
        end
      end
    end

    // R7 R8 R9: lamp test and display enable combinations
    allow = '1;
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 40; c++) begin
        digits = (NDIG*4)'(c * 1237);
        point  = PW'(c % 6);
        lamp   = m[0];
        en     = m[1];
        apply_check("R7/R8/R9");
      end
    end

    // R9 toggling enable every cycle
    lamp = 1'b0;
    for (int k = 0; k < 8; k++) begin
      en = k[0];
      apply_check("R9");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule